// File: doc/BRIEF.md
# Six-Channel Wavetable Sound Generator

This block produces two digital audio mix words, left and right, from six sound channels. Each channel holds a 32-entry table of 5-bit unsigned samples. A 12-bit period counter steps through the table, and the sample it reaches is weighted by a per-channel volume and a per-side balance before all channels are summed. A CPU programs the block through a single synchronous write port. A write names a channel, a register select code and a 12-bit data word. Each channel also drives a one-cycle strobe whenever its table read position advances.

Some channels take on extra roles. Channel 1 can act as a modulator: its current sample bends the playback period of channel 0, and channel 1 is then removed from the mix. Channels 4 and 5 can replace table playback with a pseudo-random on/off noise signal. Any channel can skip its table and send a CPU-written 5-bit value straight to the mixer. Analog conversion and filtering are handled outside the block.

Top module: `wave6_synth`

## Requirements
- R1: Every left_out and right_out value is the sum, over all six channels, of sample × volume × balance, where the balance is the left or right value for that side. The sum is registered and 17 bits wide, so the largest possible total of 86490 never overflows.
- R2: Register select 2 writes data bits [4:0] into the channel's table at its write pointer. The write pointer then increments, and after entry 31 it wraps to entry 0.
- R3: Select 0 is the control register: bit 0 enables the channel, bit 1 selects direct mode and bit 2 selects modulation (channel 1 only). Select 1 sets the period P, and P = 0 silences playback. When a channel is enabled with P ≠ 0, entry 0 plays for P cycles. After that, the read pointer advances every P cycles, wraps after entry 31, and each advance pulses that channel's bit of sample_stb for one cycle.
- R4: While a channel is enabled in table mode with period 0, its sample is 0.
- R5: In direct mode (control bit 1), the value written with select 3 (bits [4:0]) goes to the mixer. The table is not stepped and no strobe is produced.
- R6: When channel 1 has control bit 2 set, channel 0 steps every max(1, P0 + s1 − 16) cycles, where s1 is channel 1's current sample, and channel 1 adds nothing to the mix.
- R7: Channels 0 to 3 ignore select 6, so their output is unaffected by writes to it.
- R8: On channels 4 and 5, select 6 enables noise with bit 5 and sets the rate r with bits [4:0]. The sample is then 31 or 0 from a 15-bit LFSR that shifts every (32 − r) × 4 cycles.
- R9: A control write with bit 0 clear resets both the table write pointer and the read pointer to entry 0.
- R10: After reset, all registers are zero and left_out, right_out and sample_stb are 0.
- R11: A disabled channel contributes 0 to the mix. Select 4 sets the volume from bits [4:0]. Select 5 sets the left balance from bits [7:4] and the right balance from bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 3 | Channel addressed by the write (0 to 5) |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 12 | Write data |
| sample_stb | output | 6 | Per-channel read-pointer advance pulse |
| left_out | output | 17 | Registered left mix |
| right_out | output | 17 | Registered right mix |

## Verification
The mixer arithmetic is checked with a table of direct-mode vectors. These vary the channel, sample, volume and both balances one channel at a time, which separates a wrong weighting factor from a wrong side or a wrong channel, and a final case with all six channels at full scale exposes any overflow. Table playback uses a scrambled sample sequence that runs past entry 31, so an off-by-one step, a missed wrap or a stale first entry each show up as a different wrong value. The modulation case compares channel 0's step interval with the modulator on and off. The noise case shows that the output takes only the two allowed levels and that both occur. Writes to the pointer-reset control and to the noise register on a channel without noise are checked by playing back the table and watching the mix.

// File: rtl/wtsg_pkg.sv
package wtsg_pkg;
  localparam int NCH   = 6;
  localparam int SW    = 5;
  localparam int DEPTH = 32;
  localparam int PW    = 12;
  localparam int VW    = 5;
  localparam int BW    = 4;
  localparam int DW    = 12;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_PERIOD  = 3'd1,
    SEL_WAVE    = 3'd2,
    SEL_DIRECT  = 3'd3,
    SEL_VOLUME  = 3'd4,
    SEL_BALANCE = 3'd5,
    SEL_NOISE   = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/wtsg_noise.sv
module wtsg_noise #(
  parameter int LW    = 15,
  parameter int RW    = 5,
  parameter int SCALE = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [RW-1:0] rate,
  output logic          bit_o
);
  localparam int CW = RW + SCALE + 1;

  logic [LW-1:0] lfsr;
  logic [CW-1:0] cnt;
  logic [CW-1:0] span;

  always_comb span = (CW'(1 << RW) - CW'(rate)) << SCALE;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr <= LW'(1);
      cnt  <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt == '0) begin
      cnt  <= span - CW'(1);
      lfsr <= {lfsr[LW-2:0], lfsr[LW-1] ^ lfsr[LW-2]};
    end else begin
      cnt <= cnt - CW'(1);
    end
  end

  assign bit_o = lfsr[0];

  // R8: the shift register never locks up at all zeros
  p_lfsr_live_r8: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);
endmodule

// File: rtl/wtsg_channel.sv
module wtsg_channel
  import wtsg_pkg::*;
#(
  parameter bit HAS_NOISE    = 1'b0,
  parameter bit HAS_MOD_CTRL = 1'b0,
  parameter int SWD          = SW,
  parameter int TDEPTH       = DEPTH,
  parameter int PWD          = PW,
  parameter int VWD          = VW,
  parameter int BWD          = BW,
  parameter int DWD          = DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  reg_sel_e        wr_sel,
  input  logic [DWD-1:0]  wr_data,
  input  logic            mod_use,
  input  logic [SWD-1:0]  mod_val,
  output logic [SWD-1:0]  sample_o,
  output logic [VWD-1:0]  vol_o,
  output logic [BWD-1:0]  lbal_o,
  output logic [BWD-1:0]  rbal_o,
  output logic            mod_en_o,
  output logic            stb_o
);
  localparam int AW = $clog2(TDEPTH);
  localparam int EW = PWD + 2;
  localparam logic signed [EW-1:0] MID = EW'(1 << (SWD - 1));

  logic            en_q, dir_q, mod_q, noise_on_q, noise_bit;
  logic [PWD-1:0]  period_q;
  logic [SWD-1:0]  dval_q, rd_word, sample_q;
  logic [VWD-1:0]  vol_q;
  logic [BWD-1:0]  lbal_q, rbal_q;
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [PWD:0]    cnt, eff;
  logic            stb_q, step_ok, wave_wr, clr_wr;
  logic signed [EW-1:0] eff_s;
  logic [SWD-1:0]  mem [TDEPTH];

  assign wave_wr = wr_en && (wr_sel == SEL_WAVE);
  assign clr_wr  = wr_en && (wr_sel == SEL_CTRL) && !wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; dir_q <= 1'b0; period_q <= '0; dval_q <= '0;
      vol_q <= '0; lbal_q <= '0; rbal_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CTRL:    begin en_q <= wr_data[0]; dir_q <= wr_data[1]; end
        SEL_PERIOD:  period_q <= wr_data[PWD-1:0];
        SEL_DIRECT:  dval_q   <= wr_data[SWD-1:0];
        SEL_VOLUME:  vol_q    <= wr_data[VWD-1:0];
        SEL_BALANCE: begin
          lbal_q <= wr_data[2*BWD-1:BWD];
          rbal_q <= wr_data[BWD-1:0];
        end
        default: ;
      endcase
    end
  end

  generate
    if (HAS_MOD_CTRL) begin : g_mod
      always_ff @(posedge clk) begin
        if (rst) mod_q <= 1'b0;
        else if (wr_en && wr_sel == SEL_CTRL) mod_q <= wr_data[2];
      end
    end else begin : g_no_mod
      assign mod_q = 1'b0;
    end

    if (HAS_NOISE) begin : g_noise
      logic [SWD-1:0] rate_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          noise_on_q <= 1'b0;
          rate_q     <= '0;
        end else if (wr_en && wr_sel == SEL_NOISE) begin
          noise_on_q <= wr_data[SWD];
          rate_q     <= wr_data[SWD-1:0];
        end
      end
      wtsg_noise #(.LW(15), .RW(SWD), .SCALE(2)) noise_i (
        .clk   (clk),
        .rst   (rst),
        .run   (en_q && noise_on_q && !dir_q),
        .rate  (rate_q),
        .bit_o (noise_bit)
      );
    end else begin : g_no_noise
      assign noise_on_q = 1'b0;
      assign noise_bit  = 1'b0;
    end
  endgenerate

  // effective step period, bent around the sample midpoint when modulated
  always_comb begin
    eff_s = $signed({2'b00, period_q});
    if (mod_use)
      eff_s = eff_s + $signed({{(EW - SWD){1'b0}}, mod_val}) - MID;
    if (eff_s < EW'(signed'(1))) eff = (PWD+1)'(1);
    else                          eff = eff_s[PWD:0];
  end

  assign step_ok = en_q && !dir_q && !noise_on_q && (period_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; rd_ptr <= '0; wr_ptr <= '0; stb_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (!step_ok) begin
        cnt <= eff - (PWD+1)'(1);
      end else if (cnt == '0) begin
        cnt    <= eff - (PWD+1)'(1);
        rd_ptr <= rd_ptr + AW'(1);
        stb_q  <= 1'b1;
      end else begin
        cnt <= cnt - (PWD+1)'(1);
      end
      if (wave_wr) wr_ptr <= wr_ptr + AW'(1);
      if (clr_wr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end
    end
  end

  // table storage: one write port, registered read
  always_ff @(posedge clk) begin
    if (wave_wr) mem[wr_ptr] <= wr_data[SWD-1:0];
    rd_word <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst)                      sample_q <= '0;
    else if (!en_q)               sample_q <= '0;
    else if (dir_q)               sample_q <= dval_q;
    else if (noise_on_q)          sample_q <= {SWD{noise_bit}};
    else if (period_q == '0)      sample_q <= '0;
    else                          sample_q <= rd_word;
  end

  assign sample_o = sample_q;
  assign vol_o    = vol_q;
  assign lbal_o   = lbal_q;
  assign rbal_o   = rbal_q;
  assign mod_en_o = mod_q;
  assign stb_o    = stb_q;

  // R5: no table stepping while direct mode is active
  p_direct_no_step_r5: assert property (@(posedge clk) disable iff (rst)
    (en_q && dir_q) |=> !stb_o);
  // R4: zero period silences table playback
  p_silent_period_r4: assert property (@(posedge clk) disable iff (rst)
    (en_q && !dir_q && !noise_on_q && period_q == '0) |=> (sample_o == '0));
  // R9: clearing the enable resets both pointers
  p_ptr_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> (rd_ptr == '0 && wr_ptr == '0));
  // R8: noise output takes only the two extreme levels
  p_noise_levels_r8: assert property (@(posedge clk) disable iff (rst)
    (en_q && !dir_q && noise_on_q) |=> (sample_o == '0 || sample_o == '1));
endmodule

// File: rtl/wtsg_mixer.sv
module wtsg_mixer #(
  parameter int NC  = 6,
  parameter int SWD = 5,
  parameter int VWD = 5,
  parameter int BWD = 4,
  localparam int TW = SWD + VWD + BWD,
  localparam int OW = TW + $clog2(NC)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NC-1:0][SWD-1:0] smp,
  input  logic [NC-1:0][VWD-1:0] vol,
  input  logic [NC-1:0][BWD-1:0] lbal,
  input  logic [NC-1:0][BWD-1:0] rbal,
  input  logic [NC-1:0]          mute,
  output logic [OW-1:0]          left_o,
  output logic [OW-1:0]          right_o
);
  logic [OW-1:0] acc_l, acc_r;
  logic          quiet;

  always_comb begin
    acc_l = '0;
    acc_r = '0;
    quiet = 1'b1;
    for (int c = 0; c < NC; c++) begin
      if (!mute[c]) begin
        acc_l = acc_l + OW'(TW'(smp[c]) * TW'(vol[c]) * TW'(lbal[c]));
        acc_r = acc_r + OW'(TW'(smp[c]) * TW'(vol[c]) * TW'(rbal[c]));
        if (smp[c] != '0) quiet = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_o  <= '0;
      right_o <= '0;
    end else begin
      left_o  <= acc_l;
      right_o <= acc_r;
    end
  end

  // R11: when no audible channel carries a sample the mix is zero next cycle
  p_quiet_mix_r11: assert property (@(posedge clk) disable iff (rst)
    quiet |=> (left_o == '0 && right_o == '0));
endmodule

// File: rtl/wave6_synth.sv
module wave6_synth
  import wtsg_pkg::*;
#(
  parameter int NC  = NCH,
  parameter int SWD = SW,
  parameter int VWD = VW,
  parameter int BWD = BW,
  parameter int PWD = PW,
  parameter int DWD = DW,
  localparam int OW = SWD + VWD + BWD + $clog2(NC)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [2:0]     wr_chan,
  input  logic [2:0]     wr_sel,
  input  logic [DWD-1:0] wr_data,
  output logic [NC-1:0]  sample_stb,
  output logic [OW-1:0]  left_out,
  output logic [OW-1:0]  right_out
);
  logic [NC-1:0][SWD-1:0] smp;
  logic [NC-1:0][VWD-1:0] vol;
  logic [NC-1:0][BWD-1:0] lbal, rbal;
  logic [NC-1:0]          mod_en, mute;
  reg_sel_e               sel;

  assign sel = reg_sel_e'(wr_sel);

  generate
    for (genvar c = 0; c < NC; c++) begin : g_ch
      wtsg_channel #(
        .HAS_NOISE    (c >= 4),
        .HAS_MOD_CTRL (c == 1),
        .SWD(SWD), .TDEPTH(DEPTH), .PWD(PWD), .VWD(VWD), .BWD(BWD), .DWD(DWD)
      ) ch_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en && (wr_chan == 3'(c))),
        .wr_sel   (sel),
        .wr_data  (wr_data),
        .mod_use  ((c == 0) ? mod_en[1] : 1'b0),
        .mod_val  (smp[1]),
        .sample_o (smp[c]),
        .vol_o    (vol[c]),
        .lbal_o   (lbal[c]),
        .rbal_o   (rbal[c]),
        .mod_en_o (mod_en[c]),
        .stb_o    (sample_stb[c])
      );
      assign mute[c] = (c == 1) ? mod_en[1] : 1'b0;
    end
  endgenerate

  wtsg_mixer #(.NC(NC), .SWD(SWD), .VWD(VWD), .BWD(BWD)) mix_i (
    .clk     (clk),
    .rst     (rst),
    .smp     (smp),
    .vol     (vol),
    .lbal    (lbal),
    .rbal    (rbal),
    .mute    (mute),
    .left_o  (left_out),
    .right_o (right_out)
  );
endmodule

// File: tb/wave6_synth_tb_top.sv
module wave6_synth_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_chan = '0;
  logic [2:0]  wr_sel = '0;
  logic [11:0] wr_data = '0;
  logic [5:0]  sample_stb;
  logic [16:0] left_out, right_out;

  int applied = 0;
  int miscompares = 0;
  int zeros, fulls, others, strobes, maxl, ival;
  int tbl [32];

  always #2 clk = ~clk;

  wave6_synth dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan), .wr_sel(wr_sel),
    .wr_data(wr_data), .sample_stb(sample_stb), .left_out(left_out),
    .right_out(right_out)
  );

  localparam int NV = 8;
  localparam int V_CH [NV] = '{0, 1, 2, 3, 4, 5, 2, 3};
  localparam int V_D  [NV] = '{31, 10, 5, 1, 17, 31, 0, 30};
  localparam int V_V  [NV] = '{31, 3, 7, 1, 20, 31, 31, 16};
  localparam int V_LB [NV] = '{15, 2, 0, 1, 8, 15, 15, 4};
  localparam int V_RB [NV] = '{15, 0, 9, 1, 3, 0, 15, 12};
  localparam int V_EL [NV] = '{14415, 60, 0, 1, 2720, 14415, 0, 1920};
  localparam int V_ER [NV] = '{14415, 0, 315, 1, 1020, 0, 0, 5760};

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = 3'(ch); wr_sel = 3'(sel); wr_data = 12'(data);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_stb(input int ch);
    do @(negedge clk); while (!sample_stb[ch]);
  endtask

  task automatic measure(input int ch, output int n);
    wait_stb(ch);
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_stb[ch]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    do_reset();
    // R10: reset state
    chk("R10 left", int'(left_out), 0);
    chk("R10 right", int'(right_out), 0);
    chk("R10 stb", int'(sample_stb), 0);

    // R1: direct-mode vector walk across channels and weightings
    for (int i = 0; i < NV; i++) begin
      wr(V_CH[i], 3, V_D[i]);
      wr(V_CH[i], 4, V_V[i]);
      wr(V_CH[i], 5, (V_LB[i] << 4) | V_RB[i]);
      wr(V_CH[i], 0, 3);
      wait_cyc(5);
      chk("R1 left", int'(left_out), V_EL[i]);
      chk("R1 right", int'(right_out), V_ER[i]);
      wr(V_CH[i], 0, 0);
      wait_cyc(5);
      chk("R11 disabled", int'(left_out) + int'(right_out), 0);
    end

    // R1: all six at full scale, no overflow
    for (int c = 0; c < 6; c++) begin
      wr(c, 3, 31); wr(c, 4, 31); wr(c, 5, 8'hFF); wr(c, 0, 3);
    end
    wait_cyc(5);
    chk("R1 full left", int'(left_out), 86490);
    chk("R1 full right", int'(right_out), 86490);

    // R4 / R7: period 0 silent, noise write on channel 2 ignored
    do_reset();
    for (int i = 0; i < 32; i++) wr(2, 2, 25);
    wr(2, 4, 1); wr(2, 5, 8'h11); wr(2, 6, 8'h3F); wr(2, 0, 1);
    maxl = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (int'(left_out) > maxl) maxl = int'(left_out);
    end
    chk("R4 R7 period0 silent", maxl, 0);
    wr(2, 1, 6);
    wait_cyc(6);
    chk("R7 table plays despite noise write", int'(left_out), 25);

    // R5: direct mode stops stepping
    wr(2, 3, 11); wr(2, 0, 3);
    wait_cyc(3);
    strobes = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sample_stb[2]) strobes++;
    end
    chk("R5 no strobes", strobes, 0);
    chk("R5 direct value", int'(left_out), 11);

    // R2 / R3: scrambled table, step order and wrap
    do_reset();
    for (int i = 0; i < 32; i++) begin
      tbl[i] = (i * 7 + 3) % 32;
      wr(3, 2, tbl[i]);
    end
    wr(3, 4, 1); wr(3, 5, 8'h11); wr(3, 1, 40); wr(3, 0, 1);
    wait_cyc(6);
    chk("R3 first entry", int'(left_out), tbl[0]);
    for (int k = 1; k <= 34; k++) begin
      wait_stb(3);
      wait_cyc(5);
      chk("R2 R3 step", int'(left_out), tbl[k % 32]);
    end
    measure(3, ival);
    chk("R3 interval", ival, 40);

    // R9 / R2: pointer reset and write-pointer wrap
    wr(3, 0, 0);
    wr(3, 2, 9);
    for (int i = 1; i < 32; i++) wr(3, 2, i);
    wr(3, 2, 17);
    wr(3, 0, 1);
    wait_cyc(6);
    chk("R9 R2 entry0 rewritten", int'(left_out), 17);
    wait_stb(3);
    wait_cyc(5);
    chk("R9 entry1", int'(left_out), 1);

    // R6: modulation of channel 0 by channel 1
    do_reset();
    for (int i = 0; i < 32; i++) wr(1, 2, 20);
    wr(1, 1, 1000); wr(1, 4, 15); wr(1, 5, 8'hFF); wr(1, 0, 5);
    for (int i = 0; i < 32; i++) wr(0, 2, i);
    wr(0, 4, 0); wr(0, 1, 30); wr(0, 0, 1);
    measure(0, ival);
    measure(0, ival);
    chk("R6 modulated interval", ival, 34);
    chk("R6 modulator muted", int'(left_out), 0);
    wr(1, 0, 1);
    wait_cyc(5);
    chk("R6 unmuted when off", int'(left_out), 4500);
    measure(0, ival);
    measure(0, ival);
    chk("R6 plain interval", ival, 30);

    // R8: noise on channel 4
    do_reset();
    wr(4, 4, 1); wr(4, 5, 8'h10); wr(4, 6, 8'h3F); wr(4, 0, 1);
    wait_cyc(4);
    zeros = 0; fulls = 0; others = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (left_out == 0) zeros++;
      else if (left_out == 31) fulls++;
      else others++;
    end
    chk("R8 only two levels", others, 0);
    chk("R8 zero seen", int'(zeros > 0), 1);
    chk("R8 full seen", int'(fulls > 0), 1);

    finish_up();
  end
endmodule